// File: doc/BRIEF.md
# Stack Pointer and Subroutine Linkage Unit

This unit owns the stack pointer of an 8-bit processor whose stack sits in a single fixed 256-byte page. It carries out six stack operations on request: pushing a byte, pulling a byte, a subroutine call that saves a return address and supplies a jump target, a subroutine return that rebuilds the program counter, copying the pointer out to the X register, and loading the pointer from X. It drives a byte-wide memory port with a combinational read, and it reports each result together with the number of cycles the operation costs beyond its base timing.

The call saves the address of the last byte of the call instruction, which is the incoming next-instruction address minus one. The high byte is pushed first and the low byte second. A return pops the low byte and then the high byte, and adds one to the result. Pushes decrement the pointer before writing. Pulls read before incrementing. The pointer wraps modulo 256, so no access leaves the stack page. Calls and returns take two cycles and hold `busy` during the second one. Every other operation takes one cycle.

Top module: `stack_linkage_unit`

## Requirements
- R1: After reset, `spOut` is 0xFE and `busy`, `done`, `memWe` and `memRe` are low.
- R2: An accepted push (code 1) writes `pushData` at address 0x0100 + (SP − 1) in the accept cycle and leaves SP one lower. `done` pulses the next cycle with `extraCycles` = 1.
- R3: An accepted pull (code 2) reads address 0x0100 + SP in the accept cycle and leaves SP one higher. `done` pulses the next cycle with the byte on `pullData` and `extraCycles` = 1.
- R4: An accepted call (code 3) writes the high byte of (`pcIn` − 1) at 0x0100 + SP − 1 in the accept cycle. It writes the low byte at 0x0100 + SP − 2 in the next cycle. It then pulses `done` and `pcLoad` with `pcOut` = `target`, SP lowered by 2 and `extraCycles` = 2.
- R5: An accepted return (code 4) reads the low byte at 0x0100 + SP in the accept cycle and the high byte at 0x0100 + SP + 1 in the next cycle. It then pulses `done` and `pcLoad` with `pcOut` = {high, low} + 1 modulo 65536, SP raised by 2 and `extraCycles` = 4.
- R6: The pointer wraps modulo 256. Every memory access has address bits 15:8 equal to 0x01. Read and write never occur in the same cycle.
- R7: `busy` is high for exactly the one cycle after a call or return is accepted. A request presented while `busy` is high is ignored.
- R8: Code 5 copies SP to `xOut` and pulses `flagWe`, with `flagZ` = (SP == 0), `flagN` = SP bit 7 and `extraCycles` = 0.
- R9: Code 6 loads SP from `xIn`, leaves `flagWe` low and reports `extraCycles` = 0.
- R10: A return issued straight after reset, with 0xFF in both bytes 0x01FE and 0x01FF, yields `pcOut` = 0x0000 and SP = 0x00.
- R11: Codes 0 and 7 do nothing. They make no memory access, give no `done` pulse and leave SP unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation request |
| opCode | input | 3 | Operation code (see R2–R11) |
| pushData | input | 8 | Byte to push |
| pcIn | input | 16 | Address of the instruction after the call |
| target | input | 16 | Call destination |
| xIn | input | 8 | X register value for a pointer load |
| memRdata | input | 8 | Memory read data, valid in the same cycle |
| memAddr | output | 16 | Memory address |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| memWdata | output | 8 | Memory write data |
| busy | output | 1 | Second step of a call or return in progress |
| done | output | 1 | Result valid pulse |
| extraCycles | output | 3 | Cycle cost beyond base |
| pullData | output | 8 | Pulled byte |
| pcLoad | output | 1 | New program counter valid |
| pcOut | output | 16 | New program counter |
| xOut | output | 8 | Pointer copy for X |
| flagWe | output | 1 | Flag update strobe |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Sign flag |
| spOut | output | 8 | Current stack pointer |

## Verification
The hardest cases to reach are a two-byte call or return whose pointer crosses the 0x00/0xFF boundary between its two accesses, and a request that arrives during the busy cycle. Random sequences mixed with pointer loads from X place the pointer near both ends of the page, so straddling calls and returns occur often. The bench also drives a competing push in every busy cycle and checks that neither memory nor the pointer moves because of it. A directed return straight after reset checks the top-level exit value.

// File: rtl/stack_link_pkg.sv
package stack_link_pkg;
  localparam int BYTE_W = 8;
  localparam int PC_W   = 16;
  localparam int COST_W = 3;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_PULL = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_SP2X = 3'd5,
    OP_X2SP = 3'd6,
    OP_RSVD = 3'd7
  } stack_op_e;

  typedef struct packed {
    logic preDec;
    logic postInc;
    logic spLoad;
    logic memWr;
    logic memRd;
    logic wrHi;
    logic latchLo;
    logic finPush;
    logic finPull;
    logic finCall;
    logic finRet;
    logic finSp2x;
    logic finX2sp;
  } stack_ctl_t;

  localparam logic [COST_W-1:0] COST_PUSHPULL = 3'd1;
  localparam logic [COST_W-1:0] COST_CALL     = 3'd2;
  localparam logic [COST_W-1:0] COST_RET      = 3'd4;
endpackage

// File: rtl/stack_link_ctrl.sv
module stack_link_ctrl
  import stack_link_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opCode,
  output logic       busy,
  output stack_ctl_t ctl
);
  typedef enum logic [1:0] {S_IDLE, S_CALL_LO, S_RET_HI} step_e;
  step_e stepQ, stepD;
  stack_op_e op;

  assign op   = stack_op_e'(opCode);
  assign busy = (stepQ != S_IDLE);

  always_comb begin
    ctl   = '0;
    stepD = stepQ;
    unique case (stepQ)
      S_IDLE: if (opValid) begin
        unique case (op)
          OP_PUSH: begin ctl.preDec = 1'b1; ctl.memWr = 1'b1; ctl.finPush = 1'b1; end
          OP_PULL: begin ctl.postInc = 1'b1; ctl.memRd = 1'b1; ctl.finPull = 1'b1; end
          OP_CALL: begin ctl.preDec = 1'b1; ctl.memWr = 1'b1; ctl.wrHi = 1'b1; stepD = S_CALL_LO; end
          OP_RET:  begin ctl.postInc = 1'b1; ctl.memRd = 1'b1; ctl.latchLo = 1'b1; stepD = S_RET_HI; end
          OP_SP2X: ctl.finSp2x = 1'b1;
          OP_X2SP: begin ctl.spLoad = 1'b1; ctl.finX2sp = 1'b1; end
          default: ;
        endcase
      end
      S_CALL_LO: begin
        ctl.preDec = 1'b1; ctl.memWr = 1'b1; ctl.finCall = 1'b1; stepD = S_IDLE;
      end
      S_RET_HI: begin
        ctl.postInc = 1'b1; ctl.memRd = 1'b1; ctl.finRet = 1'b1; stepD = S_IDLE;
      end
      default: stepD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stepQ <= S_IDLE;
    else       stepQ <= stepD;
  end
endmodule

// File: rtl/stack_link_dpath.sv
module stack_link_dpath
  import stack_link_pkg::*;
#(
  parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [BYTE_W-1:0] SP_RESET   = 8'hFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  stack_ctl_t        ctl,
  input  logic [BYTE_W-1:0] pushData,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [PC_W-1:0]   target,
  input  logic [BYTE_W-1:0] xIn,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [PC_W-1:0]   memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [BYTE_W-1:0] memWdata,
  output logic              done,
  output logic [COST_W-1:0] extraCycles,
  output logic [BYTE_W-1:0] pullData,
  output logic              pcLoad,
  output logic [PC_W-1:0]   pcOut,
  output logic [BYTE_W-1:0] xOut,
  output logic              flagWe,
  output logic              flagZ,
  output logic              flagN,
  output logic [BYTE_W-1:0] spOut
);
  logic [BYTE_W-1:0] spQ, spD, accessPtr, lowHold;
  logic [PC_W-1:0]   retAddr, tgtHold;
  logic [COST_W-1:0] costD;
  logic              anyFin;

  assign retAddr   = pcIn - 1'b1;
  assign accessPtr = ctl.preDec ? spQ - 1'b1 : spQ;
  assign memAddr   = {STACK_PAGE, accessPtr};
  assign memWe     = ctl.memWr;
  assign memRe     = ctl.memRd;
  assign memWdata  = ctl.finPush ? pushData :
                     ctl.wrHi    ? retAddr[PC_W-1:BYTE_W] : lowHold;
  assign spOut     = spQ;
  assign anyFin    = ctl.finPush | ctl.finPull | ctl.finCall |
                     ctl.finRet  | ctl.finSp2x | ctl.finX2sp;

  always_comb begin
    if (ctl.preDec)       spD = spQ - 1'b1;
    else if (ctl.postInc) spD = spQ + 1'b1;
    else if (ctl.spLoad)  spD = xIn;
    else                  spD = spQ;
  end

  always_comb begin
    if (ctl.finRet)                     costD = COST_RET;
    else if (ctl.finCall)               costD = COST_CALL;
    else if (ctl.finPush | ctl.finPull) costD = COST_PUSHPULL;
    else                                costD = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spQ         <= SP_RESET;
      lowHold     <= '0;
      tgtHold     <= '0;
      done        <= 1'b0;
      extraCycles <= '0;
      pullData    <= '0;
      pcLoad      <= 1'b0;
      pcOut       <= '0;
      xOut        <= '0;
      flagWe      <= 1'b0;
      flagZ       <= 1'b0;
      flagN       <= 1'b0;
    end else begin
      spQ    <= spD;
      done   <= anyFin;
      pcLoad <= ctl.finCall | ctl.finRet;
      flagWe <= ctl.finSp2x;
      if (anyFin) extraCycles <= costD;
      if (ctl.wrHi) begin
        lowHold <= retAddr[BYTE_W-1:0];
        tgtHold <= target;
      end
      if (ctl.latchLo) lowHold <= memRdata;
      if (ctl.finPull) pullData <= memRdata;
      if (ctl.finCall) pcOut <= tgtHold;
      if (ctl.finRet)  pcOut <= {memRdata, lowHold} + 1'b1;
      if (ctl.finSp2x) begin
        xOut  <= spQ;
        flagZ <= (spQ == '0);
        flagN <= spQ[BYTE_W-1];
      end
    end
  end
endmodule

// File: rtl/stack_linkage_unit.sv
module stack_linkage_unit
  import stack_link_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] SP_RESET   = 8'hFE
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [2:0]  opCode,
  input  logic [7:0]  pushData,
  input  logic [15:0] pcIn,
  input  logic [15:0] target,
  input  logic [7:0]  xIn,
  input  logic [7:0]  memRdata,
  output logic [15:0] memAddr,
  output logic        memWe,
  output logic        memRe,
  output logic [7:0]  memWdata,
  output logic        busy,
  output logic        done,
  output logic [2:0]  extraCycles,
  output logic [7:0]  pullData,
  output logic        pcLoad,
  output logic [15:0] pcOut,
  output logic [7:0]  xOut,
  output logic        flagWe,
  output logic        flagZ,
  output logic        flagN,
  output logic [7:0]  spOut
);
  stack_ctl_t ctl;

  stack_link_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .busy(busy), .ctl(ctl)
  );

  stack_link_dpath #(.STACK_PAGE(STACK_PAGE), .SP_RESET(SP_RESET)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pushData(pushData), .pcIn(pcIn),
    .target(target), .xIn(xIn), .memRdata(memRdata), .memAddr(memAddr),
    .memWe(memWe), .memRe(memRe), .memWdata(memWdata), .done(done),
    .extraCycles(extraCycles), .pullData(pullData), .pcLoad(pcLoad),
    .pcOut(pcOut), .xOut(xOut), .flagWe(flagWe), .flagZ(flagZ),
    .flagN(flagN), .spOut(spOut)
  );
endmodule

// File: rtl/stack_link_checker.sv
module stack_link_checker #(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [2:0]  opCode,
  input logic [7:0]  xIn,
  input logic        busy,
  input logic        memWe,
  input logic        memRe,
  input logic [15:0] memAddr,
  input logic [7:0]  spOut,
  input logic        done
);
  logic take;
  assign take = opValid && !busy;

  a_r6_page: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> memAddr[15:8] == STACK_PAGE);
  a_r6_one_access: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));
  a_r2_push_dec: assert property (@(posedge clk) disable iff (!rstN)
    (take && opCode == 3'd1) |=> spOut == $past(spOut) - 8'd1);
  a_r3_pull_inc: assert property (@(posedge clk) disable iff (!rstN)
    (take && opCode == 3'd2) |=> spOut == $past(spOut) + 8'd1);
  a_r9_load: assert property (@(posedge clk) disable iff (!rstN)
    (take && opCode == 3'd6) |=> spOut == $past(xIn));
  a_r7_busy_one: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);
  a_r7_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    (take && (opCode == 3'd3 || opCode == 3'd4)) |=> busy);
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (take && (opCode == 3'd0 || opCode == 3'd7)) |=> (!done && $stable(spOut)));
endmodule

bind stack_linkage_unit stack_link_checker #(.STACK_PAGE(STACK_PAGE)) u_chk (.*);

// File: tb/test_stack_linkage_unit.sv
module test_stack_linkage_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [7:0]  pushData = 8'h00;
  logic [15:0] pcIn = 16'h0;
  logic [15:0] target = 16'h0;
  logic [7:0]  xIn = 8'h00;
  logic [7:0]  memRdata;
  logic [15:0] memAddr;
  logic        memWe, memRe, busy, done, pcLoad, flagWe, flagZ, flagN;
  logic [7:0]  memWdata, pullData, xOut, spOut;
  logic [2:0]  extraCycles;
  logic [15:0] pcOut;

  logic [7:0] stackMem [0:255];
  int checks = 0;
  int fails = 0;
  logic [7:0] spModel;

  always #10 clk = ~clk;

  assign memRdata = stackMem[memAddr[7:0]];
  always @(posedge clk) if (memWe) stackMem[memAddr[7:0]] <= memWdata;

  stack_linkage_unit i_stack_linkage_unit (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] costOf(input logic [2:0] c);
    case (c)
      3'd1, 3'd2: return 3'd1;
      3'd3: return 3'd2;
      3'd4: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [7:0] spAfter(input logic [2:0] c, input logic [7:0] s, input logic [7:0] x);
    case (c)
      3'd1: return s - 8'd1;
      3'd2: return s + 8'd1;
      3'd3: return s - 8'd2;
      3'd4: return s + 8'd2;
      3'd6: return x;
      default: return s;
    endcase
  endfunction

  task automatic runOp(input logic [2:0] c, input logic [7:0] d, input logic [15:0] pc,
                       input logic [15:0] tg, input logic [7:0] x);
    logic [7:0] s0, eSp, pullExp;
    logic [15:0] retExp, savedAddr;
    s0 = spModel;
    eSp = spAfter(c, s0, x);
    pullExp = stackMem[s0];
    retExp = {stackMem[s0 + 8'd1], stackMem[s0]} + 16'd1;
    savedAddr = pc - 16'd1;
    @(negedge clk);
    opValid = 1'b1; opCode = c; pushData = d; pcIn = pc; target = tg; xIn = x;
    #1;
    if (memWe || memRe)
      chk(memAddr[15:8] == 8'h01, "R6", {16'h0, memAddr}, 32'h0100);
    if (c == 3'd1) chk(memWe && memAddr == {8'h01, s0 - 8'd1}, "R2", {16'h0, memAddr}, {16'h0, 8'h01, s0 - 8'd1});
    if (c == 3'd2) chk(memRe && memAddr == {8'h01, s0}, "R3", {16'h0, memAddr}, {16'h0, 8'h01, s0});
    if (c == 3'd4) chk(memRe && memAddr == {8'h01, s0}, "R5", {16'h0, memAddr}, {16'h0, 8'h01, s0});
    if (c == 3'd0 || c == 3'd7) chk(!memWe && !memRe, "R11", {30'h0, memWe, memRe}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    if (c == 3'd3 || c == 3'd4) begin
      opValid = 1'b1; opCode = 3'd1; pushData = 8'hEE; xIn = 8'h00;
      #1;
      chk(busy == 1'b1, "R7", {31'h0, busy}, 32'h1);
      @(posedge clk);
      @(negedge clk);
    end
    opValid = 1'b0; opCode = 3'd0;
    #1;
    spModel = eSp;
    chk(busy == 1'b0, "R7", {31'h0, busy}, 32'h0);
    chk(spOut == eSp, (c == 3'd6) ? "R9" : "R6", {24'h0, spOut}, {24'h0, eSp});
    if (c == 3'd0 || c == 3'd7) begin
      chk(done == 1'b0, "R11", {31'h0, done}, 32'h0);
    end else begin
      chk(done && extraCycles == costOf(c), "R2", {28'h0, done, extraCycles}, {28'h1, costOf(c)});
    end
    case (c)
      3'd1: chk(stackMem[eSp] == d, "R2", {24'h0, stackMem[eSp]}, {24'h0, d});
      3'd2: chk(pullData == pullExp, "R3", {24'h0, pullData}, {24'h0, pullExp});
      3'd3: begin
        chk(stackMem[s0 - 8'd1] == savedAddr[15:8] && stackMem[s0 - 8'd2] == savedAddr[7:0], "R4",
            {16'h0, stackMem[s0 - 8'd1], stackMem[s0 - 8'd2]}, {16'h0, savedAddr});
        chk(pcLoad && pcOut == tg, "R4", {15'h0, pcLoad, pcOut}, {15'h1, tg});
      end
      3'd4: chk(pcLoad && pcOut == retExp, "R5", {15'h0, pcLoad, pcOut}, {15'h1, retExp});
      3'd5: chk(flagWe && xOut == s0 && flagZ == (s0 == 8'h00) && flagN == s0[7], "R8",
                {21'h0, flagWe, flagZ, flagN, xOut}, {21'h4, (s0 == 8'h00), s0[7], s0});
      3'd6: chk(flagWe == 1'b0, "R9", {31'h0, flagWe}, 32'h0);
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) stackMem[i] = 8'($urandom);
    stackMem[8'hFE] = 8'hFF;
    stackMem[8'hFF] = 8'hFF;
    spModel = 8'hFE;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(spOut == 8'hFE && !busy && !done && !memWe && !memRe, "R1",
        {20'h0, spOut, busy, done, memWe, memRe}, {20'h0, 8'hFE, 4'h0});
    rstN = 1'b1;
    // R10: top-level return from reset
    runOp(3'd4, 8'h00, 16'h0000, 16'h0000, 8'h00);
    chk(pcOut == 16'h0000 && spOut == 8'h00, "R10", {8'h0, spOut, pcOut}, 32'h0);
    // R6 wrap both directions
    runOp(3'd1, 8'h5A, 16'h0, 16'h0, 8'h00);
    runOp(3'd2, 8'h00, 16'h0, 16'h0, 8'h00);
    runOp(3'd6, 8'h00, 16'h0, 16'h0, 8'h01);
    runOp(3'd3, 8'h00, 16'h1234, 16'hC000, 8'h00);
    runOp(3'd4, 8'h00, 16'h0, 16'h0, 8'h00);
    runOp(3'd5, 8'h00, 16'h0, 16'h0, 8'h00);
    runOp(3'd6, 8'h00, 16'h0, 16'h0, 8'hFF);
    runOp(3'd4, 8'h00, 16'h0, 16'h0, 8'h00);
    runOp(3'd5, 8'h00, 16'h0, 16'h0, 8'h00);
    runOp(3'd0, 8'h11, 16'h0, 16'h0, 8'h22);
    runOp(3'd7, 8'h11, 16'h0, 16'h0, 8'h22);
    runOp(3'd3, 8'h00, 16'h0000, 16'h0800, 8'h00);
    runOp(3'd4, 8'h00, 16'h0, 16'h0, 8'h00);
    for (int n = 0; n < 400; n++) begin
      logic [2:0] c;
      c = 3'($urandom_range(0, 7));
      runOp(c, 8'($urandom), 16'($urandom), 16'($urandom),
            ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 2)) : 8'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule